// File: doc/BRIEF.md
# Board Interrupt Summary and Mask Controller

This block gathers a set of level-sensitive interrupt lines from PCI slots, on-board devices and a cascade request from downstream legacy interrupt controllers, and presents them to a processor as two byte-wide I/O registers plus one combined interrupt request. Each line passes through a two-flop synchronizer. It is then gated by a per-source mask bit, where a 1 disables the source.

The two registers share their addresses between reads and writes. A byte write stores mask bits for that byte. A byte read returns the pending summary for that byte, which is the synchronized level ANDed with the inverted mask. Source index 5 is the cascade request. Indices 0 to 4 and 8 to 10 are slot interrupt lines, index 6 is the network controller and index 7 is the disk controller. The upper five bit positions of the high register have no source. They always read as zero and are not stored as mask bits. The combined request is a registered OR of every pending, unmasked source. Software uses it to decide when to read the summary.

Top module: `irq_summary_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycles after it, every stored mask bit is 1, `irq_o` is 0 and `rdata` is 0, so no source can be pending until software clears its mask.
- R2: A write with `addr` equal to `LO_ADDR` (default 0x26) stores `wdata[7:0]` as mask bits for sources 0 to 7. Bit i of the byte controls source i, and 1 disables.
- R3: A write with `addr` equal to `HI_ADDR` (default 0x27) stores `wdata[2:0]` as mask bits for sources 8 to 10. `wdata[7:3]` is ignored, and those positions stay unstored and read as zero.
- R4: A read at `LO_ADDR` places on `rdata`, one clock after the read cycle, bit i = synchronized `src_lvl[i]` AND NOT mask[i] for i in 0 to 7.
- R5: A read at `HI_ADDR` returns bits 2:0 = pending sources 8 to 10 and bits 7:3 = 0, one clock after the read cycle.
- R6: The cascade request on `src_lvl[5]` appears at low-register bit 5 and drives `irq_o` like any other source.
- R7: A change on `src_lvl` made before clock edge k is seen in the summary used by reads sampled at edge k+2 and later. Reads sampled at edges k and k+1 do not see it.
- R8: `irq_o` is the registered OR of all pending sources. It changes one clock after the pending set changes. After a mask write at edge k covers the last pending source, `irq_o` is 0 from edge k+1.
- R9: `rdata` is 0 one clock after any cycle that is not a read of `LO_ADDR` or `HI_ADDR`.
- R10: A write to any other address leaves every mask bit unchanged.
- R11: A cycle that both reads and writes the same register returns the summary formed with the mask as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe for one cycle |
| rd_en | input | 1 | Byte read strobe for one cycle |
| addr | input | ADDR_W | I/O byte offset |
| wdata | input | 8 | Mask byte to store |
| src_lvl | input | SRC_W | Level interrupt lines; index 5 is the cascade request |
| rdata | output | 8 | Summary byte, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that `wr_en`, `rd_en`, `addr` and `wdata` are stable around each rising edge. They also assume that the source lines are held long enough for the two-flop stage to follow them, so that a level sampled by the synchronizer is meaningful. The bench changes every bus input and every source line only on the falling clock edge. After it changes a source, it waits four cycles before reading the summary or checking the request, except in the latency test, which samples the exact edges named in R7 and R8.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int BYTE_W = 8;
  localparam int SUM_W  = 16;

  typedef logic [SUM_W-1:0]  sum_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } sel_e;

  // Source bits that are pending: level present and not disabled.
  function automatic sum_t pending_of(input sum_t lvl, input sum_t mask);
    return lvl & ~mask;
  endfunction

  // Byte lane picked for a read; no lane gives zero.
  function automatic byte_t byte_of(input sum_t v, input sel_e s);
    byte_t r;
    case (s)
      SEL_LO:  r = v[7:0];
      SEL_HI:  r = v[15:8];
      default: r = '0;
    endcase
    return r;
  endfunction

  // Mask after a byte write; positions without a source are forced to 0.
  function automatic sum_t load_byte(input sum_t old, input byte_t d,
                                     input sel_e s, input sum_t keep);
    sum_t n;
    n = old;
    case (s)
      SEL_LO:  n[7:0]  = d;
      SEL_HI:  n[15:8] = d;
      default: n = old;
    endcase
    return n & keep;
  endfunction

  // Vector with the low w bits set.
  function automatic sum_t low_ones(input int w);
    sum_t r;
    for (int i = 0; i < SUM_W; i++) r[i] = (i < w);
    return r;
  endfunction

endpackage

// File: rtl/isc_level_sync.sv
module isc_level_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/isc_mask_bank.sv
module isc_mask_bank
  import isc_pkg::*;
#(
  parameter int SRC_W = 11
) (
  input  logic  clk,
  input  logic  rst_n,
  input  sel_e  wr_sel,
  input  byte_t wdata,
  output sum_t  mask_ext
);

  localparam sum_t KEEP = low_ones(SRC_W);

  sum_t mask_r;
  sum_t mask_nxt;

  always_comb mask_nxt = load_byte(mask_r, wdata, wr_sel, KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_r <= KEEP;
    else        mask_r <= mask_nxt;
  end

  assign mask_ext = mask_r;

endmodule

// File: rtl/isc_summary.sv
module isc_summary
  import isc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  sum_t  lvl_ext,
  input  sum_t  mask_ext,
  input  sel_e  rd_sel,
  output sum_t  pend,
  output byte_t rdata_q
);

  always_comb pend = pending_of(lvl_ext, mask_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= byte_of(pend, rd_sel);
  end

endmodule

// File: rtl/irq_summary_ctrl.sv
module irq_summary_ctrl
  import isc_pkg::*;
#(
  parameter int          SRC_W       = 11,
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  LO_ADDR     = 8'h26,
  parameter logic [7:0]  HI_ADDR     = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [SRC_W-1:0]  src_lvl,
  output logic [7:0]        rdata,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

  // Named internal events, also used by the checker.
  sel_e             addr_sel;
  sel_e             wr_sel;
  sel_e             rd_sel;
  logic [SRC_W-1:0] sync_lvl;
  sum_t             lvl_ext;
  sum_t             mask_ext;
  sum_t             pend;
  byte_t            rdata_q;
  logic             irq_q;

  always_comb begin
    if (addr == LO_A)      addr_sel = SEL_LO;
    else if (addr == HI_A) addr_sel = SEL_HI;
    else                   addr_sel = SEL_NONE;
    wr_sel = wr_en ? addr_sel : SEL_NONE;
    rd_sel = rd_en ? addr_sel : SEL_NONE;
  end

  isc_level_sync #(
    .WIDTH  (SRC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (src_lvl),
    .dout  (sync_lvl)
  );

  assign lvl_ext = sum_t'(sync_lvl);

  isc_mask_bank #(
    .SRC_W (SRC_W)
  ) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (wr_sel),
    .wdata    (wdata),
    .mask_ext (mask_ext)
  );

  isc_summary u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_ext  (lvl_ext),
    .mask_ext (mask_ext),
    .rd_sel   (rd_sel),
    .pend     (pend),
    .rdata_q  (rdata_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end

  assign rdata = rdata_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/irq_summary_ctrl_chk.sv
module irq_summary_ctrl_chk #(
  parameter int         SRC_W   = 11,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] LO_ADDR = 8'h26,
  parameter logic [7:0] HI_ADDR = 8'h27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              irq_o,
  input logic [15:0]       mask_ext,
  input logic [15:0]       lvl_ext
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
  localparam logic [7:0] HI_KEEP = 8'((16'd1 << (SRC_W - 8)) - 16'd1);

  logic lo_hit;
  logic hi_hit;
  assign lo_hit = (addr == LO_A);
  assign hi_hit = (addr == HI_A);

  assert_mask_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lo_hit) |=> mask_ext[7:0] == $past(wdata));

  assert_mask_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hi_hit) |=> mask_ext[15:8] == ($past(wdata) & HI_KEEP));

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && lo_hit) |=> (rdata & $past(mask_ext[7:0])) == 8'h00);

  assert_hi_raz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hi_hit) |=> rdata[7:3] == 5'b0);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(lvl_ext & ~mask_ext)));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (lo_hit || hi_hit)) |=> rdata == 8'h00);

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (lo_hit || hi_hit)) |=> $stable(mask_ext));

endmodule

bind irq_summary_ctrl irq_summary_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_o    (irq_o),
  .mask_ext (mask_ext),
  .lvl_ext  (lvl_ext)
);

// File: tb/tb_irq_summary_ctrl.sv
module tb_irq_summary_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [10:0] src_lvl = '0;
  logic [7:0]  rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  logic [10:0] m_mask = '1;
  logic [10:0] m_src  = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  irq_summary_ctrl dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .src_lvl (src_lvl),
    .rdata   (rdata),
    .irq_o   (irq_o)
  );

  task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Bench model of a summary read, bit by bit.
  function automatic logic [7:0] model_read(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (a == 8'h26) r[i] = m_src[i] && !m_mask[i];
      else if (a == 8'h27 && i < 3) r[i] = m_src[8+i] && !m_mask[8+i];
    end
    return r;
  endfunction

  function automatic logic model_irq();
    logic any;
    any = 1'b0;
    for (int i = 0; i < 11; i++) if (m_src[i] && !m_mask[i]) any = 1'b1;
    return any;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h26) m_mask[7:0] = d;
    else if (a == 8'h27) m_mask[10:8] = d[2:0];
  endtask

  // Driver: one bus cycle, expected read value pushed into the scoreboard.
  task automatic bus(input logic w, input logic r, input logic [7:0] a,
                     input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
    if (w) model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [10:0] v);
    @(negedge clk);
    src_lvl = v;
    m_src   = v;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops one expectation for each read seen at a rising edge.
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard empty actual=%02h expected=none", rdata);
      end else begin
        check_eq(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    src_lvl = 11'h7FF; m_src = 11'h7FF;
    repeat (3) @(negedge clk);
    check_eq("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    check_eq("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 irq after reset, all masked", {7'b0, irq_o}, 8'h00);
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R1 lo all masked");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R1 hi all masked");

    // Unmask everything.
    bus(1'b1, 1'b0, 8'h26, 8'h00, "");
    bus(1'b1, 1'b0, 8'h27, 8'h00, "");
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R2 R4 lo all pending");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R5 hi all pending, upper zero");
    @(negedge clk);
    check_eq("R8 irq with pending", {7'b0, irq_o}, 8'h01);

    // High write ignores bits 7:3.
    bus(1'b1, 1'b0, 8'h27, 8'hF8, "");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R3 upper write bits ignored");
    bus(1'b1, 1'b0, 8'h27, 8'h05, "");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R3 partial hi mask");

    // Mixed patterns.
    bus(1'b1, 1'b0, 8'h26, 8'hA5, "");
    set_src(11'h53C);
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R4 pattern A");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R5 pattern A");
    bus(1'b1, 1'b0, 8'h26, 8'h18, "");
    set_src(11'h2DB);
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R4 pattern B");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R5 pattern B");

    // Cascade source alone.
    bus(1'b1, 1'b0, 8'h26, 8'h00, "");
    bus(1'b1, 1'b0, 8'h27, 8'h07, "");
    set_src(11'h020);
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R6 cascade bit 5");
    check_eq("R6 cascade raises irq", {7'b0, irq_o}, {7'b0, model_irq()});

    // Synchronizer and request latency.
    set_src(11'h000);
    check_eq("R8 irq idle", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    src_lvl = 11'h001; m_src = 11'h001;
    @(negedge clk);
    check_eq("R7 irq after edge k", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    check_eq("R7 irq after edge k+1", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    check_eq("R7 R8 irq after edge k+2", {7'b0, irq_o}, 8'h01);

    // Masking the last source drops the request one clock later.
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h26; wdata = 8'h01;
    model_write(8'h26, 8'h01);
    @(negedge clk);
    wr_en = 1'b0;
    check_eq("R8 irq the cycle of the mask write", {7'b0, irq_o}, 8'h01);
    @(negedge clk);
    check_eq("R8 irq after mask write", {7'b0, irq_o}, 8'h00);

    // Other addresses.
    bus(1'b1, 1'b0, 8'h26, 8'h00, "");
    set_src(11'h3FF);
    bus(1'b1, 1'b0, 8'h25, 8'hFF, "");
    bus(1'b1, 1'b0, 8'h28, 8'hFF, "");
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R10 lo mask unchanged");
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R10 hi mask unchanged");
    bus(1'b0, 1'b1, 8'h28, 8'h00, "R9 read other address");
    bus(1'b0, 1'b0, 8'h26, 8'h00, "");
    check_eq("R9 rdata idle", rdata, 8'h00);

    // Read and write together.
    bus(1'b1, 1'b1, 8'h26, 8'hFF, "R11 read uses old mask");
    bus(1'b0, 1'b1, 8'h26, 8'h00, "R11 next read uses new mask");

    // High source drop.
    bus(1'b1, 1'b0, 8'h27, 8'h00, "");
    set_src(11'h400);
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R5 hi source 10");
    set_src(11'h000);
    bus(1'b0, 1'b1, 8'h27, 8'h00, "R5 hi source dropped");
    check_eq("R8 irq after drop", {7'b0, irq_o}, 8'h00);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4 scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule